// File: doc/BRIEF.md
# Receive Header Checker and MAC Serial Port

This block sits behind the demodulator of a direct-sequence receiver. Once the demodulator reports a start-frame-delimiter match, the block collects the 48-bit header in arrival order. The header holds an 8-bit rate field, an 8-bit service field, a 16-bit length field and a 16-bit check word. The block checks the header CRC. It then hands the rate, service, length and payload bits to the MAC over a three-wire serial port: data, a gated bit clock and a data-ready envelope.

Three level flags tell the MAC how far header decoding has advanced: rate field captured, length field captured, header check passed. The check word itself is never forwarded. The outgoing clock stays idle while the check word arrives. After a good header, the payload length in bits follows from the length field (in microseconds) and the rate code. The envelope closes after that many bits. A bad header, an unknown rate code or a low receive enable closes the envelope at once. Bit strobes from the demodulator must be at least two clock cycles apart.

Top module: `rx_hdr_mac_port`

## Requirements
- R1: While `rx_en` is low, `dat_env` is low from the next cycle on, `sfd_pulse` and bit strobes have no effect, and `ser_clk` stays at its idle level (equal to `clk_inv`).
- R2: With `dat_env` low and `rx_en` high, a `sfd_pulse` raises `dat_env` in the next cycle. A `sfd_pulse` that arrives while `dat_env` is high is ignored, and bit counting continues.
- R3: Each accepted header or payload bit appears on `ser_dat` in the cycle after its strobe. The non-inverted `ser_clk` is high for exactly the following cycle, so the MAC samples on its rising edge. Bits are forwarded in arrival order: rate field bits 0..7, service bits 0..7, length bits 0..15 (each field LSB first), then the payload.
- R4: During the 16 check-word bits (header bits 32..47), `ser_clk` produces no pulse and no bit is forwarded.
- R5: `sig_rdy` rises after the 8th header bit, `len_rdy` after the 32nd, and `hcrc_ok` after the 48th bit if the header is good. All three stay high while `dat_env` is high and clear when it drops.
- R6: The check word is the ones complement of a CRC-16 (polynomial x^16+x^12+x^5+1, register preset to 0xFFFF, MSB-first shift) over header bits 0..31, sent register bit 15 first. A match with a known rate code sets `hcrc_ok`.
- R7: A check-word mismatch, or a rate field that is not one of 0x0A, 0x14, 0x37 or 0x6E, lowers `dat_env` and the flags in the cycle after the 48th bit. No further bits are forwarded.
- R8: The payload length in bits is L for rate 0x0A, 2L for 0x14, floor(11L/2) for 0x37 and 11L for 0x6E, where L is the length field.
- R9: `dat_env` stays high until the last payload bit's clock pulse has ended and drops two cycles later. With a payload of zero bits it drops one cycle after `hcrc_ok` rises.
- R10: Lowering `rx_en` during a frame drops `dat_env` in the next cycle and cancels any pending clock pulse.
- R11: With `clk_inv` high, `ser_clk` is the complement of the non-inverted clock: idle high, with a low pulse per forwarded bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low means standby |
| bit_vld | input | 1 | One-cycle strobe marking a demodulated bit |
| bit_in | input | 1 | Demodulated bit, valid with `bit_vld` |
| sfd_pulse | input | 1 | One-cycle start-frame-delimiter detect |
| clk_inv | input | 1 | Selects the polarity of `ser_clk` |
| ser_dat | output | 1 | Serial data to the MAC |
| ser_clk | output | 1 | Gated bit clock to the MAC |
| dat_env | output | 1 | Data-ready envelope |
| sig_rdy | output | 1 | Rate field captured |
| len_rdy | output | 1 | Length field captured |
| hcrc_ok | output | 1 | Header check passed |

## Verification
The bench targets these corner cases:

- **Check-word gating.** It counts clock pulses across the 16 check-word bits. A design that kept the clock running would hand the CRC to the MAC as payload.
- **Payload length per rate code.** It runs all four rate codes, including an odd length at the 0x37 rate where the half bit must be dropped, and a zero-length frame. A wrong multiplier, or rounding up, shows up as one bit too many or too few and an envelope that closes at the wrong time.
- **Header errors.** It flips one check-word bit, and separately sends an unknown rate code with a correct CRC. A design that ignored either would keep the envelope open and go on forwarding bits.
- **Abort, stray SFD and polarity.** It drops `rx_en` in mid-payload. It sends a second SFD during the header, which a careless design would treat as a restart, moving every flag late. It repeats a full frame with the clock inverted.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

  localparam int RXH_SIG_W = 8;
  localparam int RXH_LEN_W = 16;
  localparam int RXH_CRC_W = 16;
  localparam int RXH_CNT_W = RXH_LEN_W + 4;

  localparam logic [RXH_SIG_W-1:0] RATE_R1  = 8'h0A;
  localparam logic [RXH_SIG_W-1:0] RATE_R2  = 8'h14;
  localparam logic [RXH_SIG_W-1:0] RATE_R55 = 8'h37;
  localparam logic [RXH_SIG_W-1:0] RATE_R11 = 8'h6E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CRC,
    ST_PAY,
    ST_DRAIN
  } rxh_state_e;

  // One serial step of an MSB-first CRC register.
  function automatic logic [RXH_CRC_W-1:0] crc_step(
    input logic [RXH_CRC_W-1:0] cur,
    input logic [RXH_CRC_W-1:0] poly,
    input logic                 din
  );
    logic                 fb;
    logic [RXH_CRC_W-1:0] nxt;
    fb  = din ^ cur[RXH_CRC_W-1];
    nxt = {cur[RXH_CRC_W-2:0], 1'b0};
    if (fb) nxt = nxt ^ poly;
    return nxt;
  endfunction

  function automatic logic rate_known(input logic [RXH_SIG_W-1:0] code);
    return (code == RATE_R1) || (code == RATE_R2) ||
           (code == RATE_R55) || (code == RATE_R11);
  endfunction

  // Payload bits from the length in microseconds and the rate code.
  function automatic logic [RXH_CNT_W-1:0] payload_bits(
    input logic [RXH_SIG_W-1:0] code,
    input logic [RXH_LEN_W-1:0] len
  );
    logic [RXH_CNT_W-1:0] l;
    logic [RXH_CNT_W-1:0] x11;
    l   = RXH_CNT_W'(len);
    x11 = (l << 3) + (l << 1) + l;
    case (code)
      RATE_R1:  return l;
      RATE_R2:  return l << 1;
      RATE_R55: return x11 >> 1;
      RATE_R11: return x11;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/rxh_crc16.sv
module rxh_crc16 #(
  parameter int                  CRC_W = 16,
  parameter logic [CRC_W-1:0]    POLY  = 16'h1021,
  parameter logic [CRC_W-1:0]    SEED  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  import rxh_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= SEED;
    else if (clr)   crc <= SEED;
    else if (step)  crc <= crc_step(crc, POLY, din);
  end

endmodule

// File: rtl/rxh_ser_tx.sv
module rxh_ser_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd,
  input  logic din,
  input  logic flush,
  input  logic clk_inv,
  output logic ser_dat,
  output logic ser_clk,
  output logic pend
);
  logic fwd_d;
  logic clk_q;

  // Data changes one cycle before its clock pulse, so it is stable at the edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_dat <= 1'b0;
      fwd_d   <= 1'b0;
      clk_q   <= 1'b0;
    end else if (flush) begin
      ser_dat <= 1'b0;
      fwd_d   <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      if (fwd) ser_dat <= din;
      fwd_d <= fwd;
      clk_q <= fwd_d;
    end
  end

  assign ser_clk = clk_q ^ clk_inv;
  assign pend    = fwd_d | clk_q;

endmodule

// File: rtl/rxh_hdr_ctl.sv
module rxh_hdr_ctl #(
  parameter int SIG_W = 8,
  parameter int SVC_W = 8,
  parameter int LEN_W = 16,
  parameter int CRC_W = 16,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             sfd_pulse,
  input  logic [CRC_W-1:0] crc_val,
  input  logic             pend,
  output logic             crc_clr,
  output logic             crc_step_en,
  output logic             fwd,
  output logic             flush,
  output logic             in_frame,
  output logic             in_crc,
  output logic             hdr_fail,
  output logic             sig_rdy,
  output logic             len_rdy,
  output logic             hcrc_ok
);
  import rxh_pkg::*;

  localparam int HDR_W  = SIG_W + SVC_W + LEN_W;
  localparam int BCNT_W = $clog2(HDR_W + 1);
  localparam int CIDX_W = $clog2(CRC_W);

  rxh_state_e          state;
  logic [HDR_W-1:0]    hdr_sr;
  logic [BCNT_W-1:0]   bcnt;
  logic [CIDX_W-1:0]   cidx;
  logic                crc_bad;
  logic [CNT_W-1:0]    pay_left;

  logic                take;
  logic                exp_bit;
  logic                mis;
  logic                crc_last;
  logic                hdr_bad;
  logic [SIG_W-1:0]    sig_fld;
  logic [LEN_W-1:0]    len_fld;
  logic [CNT_W-1:0]    pay_total;

  assign take      = rx_en & bit_vld;
  assign sig_fld   = hdr_sr[SIG_W-1:0];
  assign len_fld   = hdr_sr[HDR_W-1 -: LEN_W];
  assign pay_total = CNT_W'(payload_bits(sig_fld, len_fld));
  assign exp_bit   = ~crc_val[(CRC_W-1) - int'(cidx)];
  assign mis       = bit_in ^ exp_bit;
  assign crc_last  = (state == ST_CRC) && take && (cidx == CIDX_W'(CRC_W-1));
  assign hdr_bad   = crc_bad | mis | ~rate_known(sig_fld);

  assign crc_clr     = (state == ST_IDLE) && rx_en && sfd_pulse;
  assign crc_step_en = (state == ST_HDR) && take;
  assign fwd         = take && ((state == ST_HDR) || (state == ST_PAY));
  assign hdr_fail    = crc_last && hdr_bad;
  assign flush       = (!rx_en && (state != ST_IDLE)) || hdr_fail;
  assign in_frame    = (state != ST_IDLE);
  assign in_crc      = (state == ST_CRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hdr_sr   <= '0;
      bcnt     <= '0;
      cidx     <= '0;
      crc_bad  <= 1'b0;
      pay_left <= '0;
      sig_rdy  <= 1'b0;
      len_rdy  <= 1'b0;
      hcrc_ok  <= 1'b0;
    end else if (!rx_en) begin
      state   <= ST_IDLE;
      sig_rdy <= 1'b0;
      len_rdy <= 1'b0;
      hcrc_ok <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sfd_pulse) begin
            state   <= ST_HDR;
            bcnt    <= '0;
            cidx    <= '0;
            crc_bad <= 1'b0;
            sig_rdy <= 1'b0;
            len_rdy <= 1'b0;
            hcrc_ok <= 1'b0;
          end
        end
        ST_HDR: begin
          if (take) begin
            hdr_sr <= {bit_in, hdr_sr[HDR_W-1:1]};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == BCNT_W'(SIG_W-1)) sig_rdy <= 1'b1;
            if (bcnt == BCNT_W'(HDR_W-1)) begin
              len_rdy <= 1'b1;
              state   <= ST_CRC;
            end
          end
        end
        ST_CRC: begin
          if (take) begin
            cidx    <= cidx + 1'b1;
            crc_bad <= crc_bad | mis;
            if (crc_last) begin
              if (hdr_bad) begin
                state   <= ST_IDLE;
                sig_rdy <= 1'b0;
                len_rdy <= 1'b0;
              end else begin
                hcrc_ok  <= 1'b1;
                pay_left <= pay_total;
                state    <= (pay_total == '0) ? ST_DRAIN : ST_PAY;
              end
            end
          end
        end
        ST_PAY: begin
          if (take) begin
            pay_left <= pay_left - 1'b1;
            if (pay_left == CNT_W'(1)) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!pend) begin
            state   <= ST_IDLE;
            sig_rdy <= 1'b0;
            len_rdy <= 1'b0;
            hcrc_ok <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_hdr_mac_port.sv
module rx_hdr_mac_port #(
  parameter int SIG_W = rxh_pkg::RXH_SIG_W,
  parameter int SVC_W = 8,
  parameter int LEN_W = rxh_pkg::RXH_LEN_W,
  parameter int CRC_W = rxh_pkg::RXH_CRC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic sfd_pulse,
  input  logic clk_inv,
  output logic ser_dat,
  output logic ser_clk,
  output logic dat_env,
  output logic sig_rdy,
  output logic len_rdy,
  output logic hcrc_ok
);
  localparam int CNT_W = LEN_W + 4;

  logic [CRC_W-1:0] w_crc;
  logic             w_crc_clr;
  logic             w_crc_step;
  logic             w_fwd;
  logic             w_flush;
  logic             w_pend;
  logic             w_in_frame;
  logic             w_in_crc;
  logic             w_hdr_fail;

  rxh_crc16 #(.CRC_W(CRC_W)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (w_crc_clr),
    .step (w_crc_step),
    .din  (bit_in),
    .crc  (w_crc)
  );

  rxh_hdr_ctl #(
    .SIG_W(SIG_W), .SVC_W(SVC_W), .LEN_W(LEN_W), .CRC_W(CRC_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .sfd_pulse  (sfd_pulse),
    .crc_val    (w_crc),
    .pend       (w_pend),
    .crc_clr    (w_crc_clr),
    .crc_step_en(w_crc_step),
    .fwd        (w_fwd),
    .flush      (w_flush),
    .in_frame   (w_in_frame),
    .in_crc     (w_in_crc),
    .hdr_fail   (w_hdr_fail),
    .sig_rdy    (sig_rdy),
    .len_rdy    (len_rdy),
    .hcrc_ok    (hcrc_ok)
  );

  rxh_ser_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .fwd    (w_fwd),
    .din    (bit_in),
    .flush  (w_flush),
    .clk_inv(clk_inv),
    .ser_dat(ser_dat),
    .ser_clk(ser_clk),
    .pend   (w_pend)
  );

  assign dat_env = w_in_frame;

endmodule

// File: rtl/rx_hdr_mac_port_chk.sv
module rx_hdr_mac_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic bit_vld,
  input logic sfd_pulse,
  input logic clk_inv,
  input logic ser_clk,
  input logic dat_env,
  input logic sig_rdy,
  input logic len_rdy,
  input logic hcrc_ok,
  input logic w_in_crc,
  input logic w_hdr_fail
);

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !dat_env);

  p_env_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dat_env && rx_en && sfd_pulse) |=> dat_env);

  p_crc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_in_crc && rx_en && bit_vld) |=> (ser_clk == clk_inv) ##1 (ser_clk == clk_inv));

  p_flag_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hcrc_ok |-> len_rdy) and (len_rdy |-> sig_rdy) and (sig_rdy |-> dat_env));

  p_fail_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_hdr_fail |=> (!dat_env && !sig_rdy && !hcrc_ok));

  p_idle_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_env |-> (ser_clk == clk_inv));

endmodule

bind rx_hdr_mac_port rx_hdr_mac_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .bit_vld   (bit_vld),
  .sfd_pulse (sfd_pulse),
  .clk_inv   (clk_inv),
  .ser_clk   (ser_clk),
  .dat_env   (dat_env),
  .sig_rdy   (sig_rdy),
  .len_rdy   (len_rdy),
  .hcrc_ok   (hcrc_ok),
  .w_in_crc  (w_in_crc),
  .w_hdr_fail(w_hdr_fail)
);

// File: tb/rx_hdr_mac_port_tb.sv
module rx_hdr_mac_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic sfd_pulse = 1'b0;
  logic clk_inv = 1'b0;
  logic ser_dat, ser_clk, dat_env, sig_rdy, len_rdy, hcrc_ok;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic cap [0:1023];
  int   ncap = 0;
  logic plvl = 1'b0;
  logic hb [0:47];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_hdr_mac_port u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
    .sfd_pulse(sfd_pulse), .clk_inv(clk_inv), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .dat_env(dat_env), .sig_rdy(sig_rdy), .len_rdy(len_rdy), .hcrc_ok(hcrc_ok)
  );

  // Records one MAC bit per active edge of the serial clock.
  always @(negedge clk) begin
    logic lvl;
    lvl = ser_clk ^ clk_inv;
    if (lvl && !plvl && ncap < 1024) begin
      cap[ncap] = ser_dat;
      ncap++;
    end
    plvl = lvl;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns at the falling edge just after the strobe was sampled.
  task automatic drive_bit(input logic b);
    @(negedge clk);
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic pulse_sfd();
    @(negedge clk);
    sfd_pulse = 1'b1;
    @(negedge clk);
    sfd_pulse = 1'b0;
  endtask

  function automatic logic pay_bit(input int i);
    return logic'(((i * 13 + 5) >> 2) & 1);
  endfunction

  function automatic int exp_bits(input logic [7:0] s, input int l);
    case (s)
      8'h0A: return l;
      8'h14: return 2 * l;
      8'h37: return (11 * l) / 2;
      8'h6E: return 11 * l;
      default: return 0;
    endcase
  endfunction

  // Fills hb with the 48 header bits; tap form of the CRC-16 register.
  task automatic build_hdr(input logic [7:0] s, input logic [7:0] v,
                           input logic [15:0] l, input bit flip);
    logic [15:0] c;
    logic [15:0] n;
    logic        fb;
    for (int i = 0; i < 8; i++)  hb[i] = s[i];
    for (int i = 0; i < 8; i++)  hb[8+i] = v[i];
    for (int i = 0; i < 16; i++) hb[16+i] = l[i];
    c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      fb = hb[i] ^ c[15];
      n = {c[14:0], fb};
      n[5]  = c[4] ^ fb;
      n[12] = c[11] ^ fb;
      c = n;
    end
    c = ~c;
    for (int j = 0; j < 16; j++) hb[32+j] = c[15-j];
    if (flip) hb[40] = ~hb[40];
  endtask

  task automatic t_reset();
    chk("R1 reset env", int'(dat_env), 0);
    chk("R1 reset clk", int'(ser_clk), 0);
    chk("R5 reset flags", int'({sig_rdy, len_rdy, hcrc_ok}), 0);
  endtask

  task automatic t_standby();
    int n0;
    rx_en = 1'b0;
    n0 = ncap;
    pulse_sfd();
    chk("R1 sfd in standby", int'(dat_env), 0);
    for (int i = 0; i < 3; i++) begin drive_bit(1'b1); idle(2); end
    chk("R1 no bits in standby", ncap, n0);
    chk("R1 clk idle in standby", int'(ser_clk), 0);
    rx_en = 1'b1;
    idle(2);
  endtask

  // Full good frame; optional stray SFD inside the header.
  task automatic t_good(input logic [7:0] s, input logic [7:0] v,
                        input logic [15:0] l, input bit sfd_mid, input string tag);
    int nexp, nhdr, errs;
    build_hdr(s, v, l, 1'b0);
    nexp = exp_bits(s, int'(l));
    pulse_sfd();
    chk({"R2 env rise ", tag}, int'(dat_env), 1);
    ncap = 0;
    for (int i = 0; i < 32; i++) begin
      drive_bit(hb[i]);
      if (i == 7) begin
        chk({"R5 sig_rdy ", tag}, int'(sig_rdy), 1);
        chk({"R5 len_rdy early ", tag}, int'(len_rdy), 0);
      end
      if (i == 31) chk({"R5 len_rdy ", tag}, int'(len_rdy), 1);
      if (sfd_mid && i == 3) begin
        sfd_pulse = 1'b1;
        @(negedge clk);
        sfd_pulse = 1'b0;
        idle(1);
      end else idle(2);
    end
    nhdr = ncap;
    chk({"R3 header count ", tag}, nhdr, 32);
    for (int i = 32; i < 48; i++) begin
      drive_bit(hb[i]);
      if (i == 47) begin
        chk({"R6 hcrc_ok ", tag}, int'(hcrc_ok), 1);
        chk({"R6 env after crc ", tag}, int'(dat_env), 1);
      end
      idle(2);
    end
    chk({"R4 no pulses in crc ", tag}, ncap, nhdr);
    errs = 0;
    for (int i = 0; i < 32; i++) if (cap[i] !== hb[i]) errs++;
    chk({"R3 header bits ", tag}, errs, 0);
    if (nexp == 0) begin
      chk({"R9 zero payload drop ", tag}, int'(dat_env), 0);
    end else begin
      for (int i = 0; i < nexp; i++) begin
        drive_bit(pay_bit(i));
        if (i == nexp - 1) begin
          chk({"R9 env held to last ", tag}, int'(dat_env), 1);
          idle(3);
          chk({"R9 env drop ", tag}, int'(dat_env), 0);
        end else idle(2);
      end
    end
    chk({"R8 bit count ", tag}, ncap, 32 + nexp);
    errs = 0;
    for (int i = 0; i < nexp; i++) if (cap[32+i] !== pay_bit(i)) errs++;
    chk({"R3 payload bits ", tag}, errs, 0);
    chk({"R5 flags cleared ", tag}, int'({sig_rdy, len_rdy, hcrc_ok}), 0);
    drive_bit(1'b1);
    idle(3);
    chk({"R9 extra bit ignored ", tag}, ncap, 32 + nexp);
  endtask

  task automatic t_bad(input logic [7:0] s, input bit flip, input string tag);
    build_hdr(s, 8'h00, 16'd4, flip);
    pulse_sfd();
    ncap = 0;
    for (int i = 0; i < 48; i++) begin
      drive_bit(hb[i]);
      if (i == 47) begin
        chk({"R7 env drop ", tag}, int'(dat_env), 0);
        chk({"R7 flags clear ", tag}, int'({sig_rdy, len_rdy, hcrc_ok}), 0);
      end
      idle(2);
    end
    for (int i = 0; i < 4; i++) begin drive_bit(1'b1); idle(2); end
    chk({"R7 nothing forwarded ", tag}, ncap, 32);
  endtask

  task automatic t_abort();
    int n0;
    build_hdr(8'h0A, 8'h00, 16'd20, 1'b0);
    pulse_sfd();
    for (int i = 0; i < 48; i++) begin drive_bit(hb[i]); idle(2); end
    for (int i = 0; i < 3; i++) begin drive_bit(pay_bit(i)); idle(2); end
    chk("R10 env before abort", int'(dat_env), 1);
    drive_bit(1'b1);
    rx_en = 1'b0;
    n0 = ncap;
    @(negedge clk);
    chk("R10 env low after abort", int'(dat_env), 0);
    idle(3);
    chk("R10 pending pulse cancelled", ncap, n0);
    rx_en = 1'b1;
    for (int i = 0; i < 3; i++) begin drive_bit(1'b0); idle(2); end
    chk("R10 frame not resumed", ncap, n0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(1);
    t_reset();
    idle(2);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_standby();
    t_good(8'h0A, 8'h00, 16'd7, 1'b0, "rate1");
    t_good(8'h14, 8'h04, 16'd5, 1'b0, "rate2");
    t_good(8'h37, 8'h00, 16'd3, 1'b0, "rate55 odd");
    t_good(8'h6E, 8'h00, 16'd2, 1'b0, "rate11");
    t_good(8'h0A, 8'h00, 16'd0, 1'b0, "zero len");
    t_good(8'h14, 8'h00, 16'd3, 1'b1, "R2 stray sfd");
    t_bad(8'h0A, 1'b1, "crc flip");
    t_bad(8'h55, 1'b0, "unknown rate");
    t_abort();
    clk_inv = 1'b1;
    idle(2);
    chk("R11 inverted idle level", int'(ser_clk), 1);
    t_good(8'h0A, 8'h00, 16'd6, 1'b0, "R11 inverted");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule